// File: doc/BRIEF.md
# Chained overflow correction pool

This block hands out extra hard-fault correction entries to memory lines on demand. Each line owns one local correction slot. Once that slot is taken, further faults of the line go to a shared pool. The pool's first level is a set-associative primary table, with the set picked by a hash of the line address. When a primary set has no free way left, that set links to one set of a collision table, which has half as many sets. All of a line's further entries go into that linked set. A line's entries therefore always stay inside one primary set and its single chained collision set.

A request is either an allocation, which records one new faulty bit (its position and the value to substitute), or a lookup, which returns every entry the line owns. Entries come back in a fixed order: local slot first, then primary-table entries, then collision-table entries. Each line keeps two state bits that say how far its entries reach. A line that never overflowed skips the pool search, and only lines that reach the collision table cause the extra-access flag. The answer to every request appears on the registered outputs one cycle after the request.

Top module: `ovf_corr_pool`

## Requirements
- R1: After synchronous reset, no response is pending and a lookup of any line returns rsp_ok=1, rsp_count=0, rsp_extra=0 and all entry slots zero.
- R2: A request accepted on a rising edge (req_valid=1) produces rsp_valid=1 in the following cycle. With no request, rsp_valid is 0 in the following cycle.
- R3: The first allocation for a line fills its local slot and reports rsp_ok=1. An entry is encoded as {position, value}: the replacement value in bit 0 and the bit position in bits POS_W:1. Returned slot i occupies rsp_ents bits [i*(POS_W+1) +: POS_W+1].
- R4: The primary set index is an XOR fold of the line address: line bit i is XORed into index bit (i mod log2(SAT_SETS)).
- R5: Later allocations take the lowest free way of the line's primary set, shared by all lines hashing there. A lookup returns the local entry, then the line's primary entries in allocation order.
- R6: When the primary set is full and has no chained collision set yet, an allocation claims the lowest unclaimed collision set, stores the entry there and reports rsp_extra=1.
- R7: Later allocations for any line of an overflowed primary set go to its already chained collision set (rsp_extra=1). The collision table has SAT_SETS/2 sets, and the chain pointer is held in two copies that must agree.
- R8: A lookup returns the line's collision entries after its primary entries and sets rsp_extra=1 exactly when the line owns collision entries. Other lines of an overflowed set see rsp_extra=0.
- R9: An allocation fails (rsp_ok=0, rsp_count=0) and changes no state when the chained collision set is full (rsp_extra=1), or when the primary set is full and no collision set is free (rsp_extra=0).
- R10: A single line may own up to 1+SAT_WAYS+GCT_WAYS entries (9 by default, more than six), and rsp_count never exceeds that bound.
- R11: An allocation response carries rsp_count=0 and zero entry slots. Lookup responses carry rsp_ok=1 with unused slots zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = lookup, 1 = allocate |
| req_line | input | LINE_AW | Line address |
| req_pos | input | POS_W | Faulty bit position (allocate) |
| req_fix | input | 1 | Value to substitute at that bit (allocate) |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Allocation stored / lookup done |
| rsp_extra | output | 1 | Collision table was accessed |
| rsp_count | output | clog2(2+SAT_WAYS+GCT_WAYS) | Number of entries returned |
| rsp_ents | output | (1+SAT_WAYS+GCT_WAYS)*(POS_W+1) | Returned entries, slot 0 in the low bits |

## Verification
The hardest states to reach are the end of the pool: a chained collision set with every way taken, and a primary set that overflows after all collision sets have been claimed. Both need dozens of allocations aimed at particular primary sets. The stimulus uses the address fold to choose lines that share a set. It overflows four sets in turn to use up the collision table, fills one line to its nine-entry bound, and then pushes a fifth set over the edge. A long pseudo-random phase afterwards mixes lookups and allocations against the exhausted pool.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_PRI  = 2'd1,
    OVF_COL  = 2'd2
  } ovf_e;

  localparam logic OP_LOOKUP = 1'b0;
  localparam logic OP_ALLOC  = 1'b1;
endpackage

// File: rtl/ocp_way_bank.sv
module ocp_way_bank #(
  parameter int SETS  = 8,
  parameter int TAG_W = 6,
  parameter int ENT_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  idx,
  input  logic                     we,
  input  logic [TAG_W-1:0]         wtag,
  input  logic [ENT_W-1:0]         went,
  output logic                     rd_vld,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [ENT_W-1:0]         rd_ent
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [ENT_W-1:0] ent_mem [SETS];
  logic [SETS-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[idx] <= wtag;
      ent_mem[idx] <= went;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[idx] <= 1'b1;
  end

  assign rd_vld = vld_q[idx];
  assign rd_tag = tag_mem[idx];
  assign rd_ent = ent_mem[idx];
endmodule

// File: rtl/ocp_local_meta.sv
module ocp_local_meta
  import ocp_pkg::*;
#(
  parameter int LINE_AW = 6,
  parameter int ENT_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINE_AW-1:0] line,
  input  logic               ent_we,
  input  logic [ENT_W-1:0]   ent_wdata,
  input  logic               st_we,
  input  ovf_e               st_wdata,
  output logic               rd_valid,
  output logic [ENT_W-1:0]   rd_ent,
  output ovf_e               rd_state
);
  localparam int LINES = 1 << LINE_AW;

  logic [ENT_W-1:0] ent_mem [LINES];
  logic [LINES-1:0] vld_q;
  ovf_e             st_q [LINES];

  always_ff @(posedge clk) begin
    if (ent_we) ent_mem[line] <= ent_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) st_q[i] <= OVF_NONE;
    end else begin
      if (ent_we) vld_q[line] <= 1'b1;
      if (st_we)  st_q[line]  <= st_wdata;
    end
  end

  assign rd_valid = vld_q[line];
  assign rd_ent   = ent_mem[line];
  assign rd_state = st_q[line];
endmodule

// File: rtl/ocp_sat.sv
module ocp_sat #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int ENT_W  = 10,
  parameter int HEAD_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(SETS)-1:0]        idx,
  input  logic                           we,
  input  logic [$clog2(WAYS)-1:0]        way,
  input  logic [TAG_W-1:0]               wtag,
  input  logic [ENT_W-1:0]               went,
  input  logic                           link_we,
  input  logic [HEAD_W-1:0]              link_head,
  output logic [WAYS-1:0]                rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
  output logic [WAYS-1:0][ENT_W-1:0]     rd_ent,
  output logic                           rd_ovf,
  output logic [HEAD_W-1:0]              rd_head_a,
  output logic [HEAD_W-1:0]              rd_head_b
);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0]   ovf_q;
  logic [HEAD_W-1:0] head_a_mem [SETS];
  logic [HEAD_W-1:0] head_b_mem [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ocp_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .idx    (idx),
      .we     (we && (way == WAY_W'(w))),
      .wtag   (wtag),
      .went   (went),
      .rd_vld (rd_vld[w]),
      .rd_tag (rd_tag[w]),
      .rd_ent (rd_ent[w])
    );
  end

  always_ff @(posedge clk) begin
    if (link_we) begin
      head_a_mem[idx] <= link_head;
      head_b_mem[idx] <= link_head;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else if (link_we) ovf_q[idx] <= 1'b1;
  end

  assign rd_ovf    = ovf_q[idx];
  assign rd_head_a = head_a_mem[idx];
  assign rd_head_b = head_b_mem[idx];
endmodule

// File: rtl/ocp_gct.sv
module ocp_gct #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int ENT_W = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(SETS)-1:0]        idx,
  input  logic                           we,
  input  logic [$clog2(WAYS)-1:0]        way,
  input  logic [TAG_W-1:0]               wtag,
  input  logic [ENT_W-1:0]               went,
  input  logic                           claim_en,
  output logic [WAYS-1:0]                rd_vld,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag,
  output logic [WAYS-1:0][ENT_W-1:0]     rd_ent,
  output logic                           free_any,
  output logic [$clog2(SETS)-1:0]        free_idx
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0] claimed_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ocp_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .idx    (idx),
      .we     (we && (way == WAY_W'(w))),
      .wtag   (wtag),
      .went   (went),
      .rd_vld (rd_vld[w]),
      .rd_tag (rd_tag[w]),
      .rd_ent (rd_ent[w])
    );
  end

  // lowest unclaimed collision set
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int s = SETS - 1; s >= 0; s--) begin
      if (!claimed_q[s]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) claimed_q <= '0;
    else if (claim_en) claimed_q[free_idx] <= 1'b1;
  end
endmodule

// File: rtl/ovf_corr_pool.sv
module ovf_corr_pool
  import ocp_pkg::*;
#(
  parameter int LINE_AW  = 6,
  parameter int POS_W    = 9,
  parameter int SAT_SETS = 8,
  parameter int SAT_WAYS = 4,
  parameter int GCT_WAYS = 4
) (
  input  logic                                                clk,
  input  logic                                                rst,
  input  logic                                                req_valid,
  input  logic                                                req_op,
  input  logic [LINE_AW-1:0]                                  req_line,
  input  logic [POS_W-1:0]                                    req_pos,
  input  logic                                                req_fix,
  output logic                                                rsp_valid,
  output logic                                                rsp_ok,
  output logic                                                rsp_extra,
  output logic [$clog2(2+SAT_WAYS+GCT_WAYS)-1:0]              rsp_count,
  output logic [(1+SAT_WAYS+GCT_WAYS)*(POS_W+1)-1:0]          rsp_ents
);
  localparam int ENT_W    = POS_W + 1;
  localparam int GCT_SETS = SAT_SETS / 2;
  localparam int SIDX_W   = $clog2(SAT_SETS);
  localparam int GIDX_W   = $clog2(GCT_SETS);
  localparam int SW_W     = $clog2(SAT_WAYS);
  localparam int GW_W     = $clog2(GCT_WAYS);
  localparam int MAX_ENT  = 1 + SAT_WAYS + GCT_WAYS;
  localparam int CNT_W    = $clog2(MAX_ENT + 1);

  function automatic logic [SIDX_W-1:0] set_of(input logic [LINE_AW-1:0] l);
    logic [SIDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < LINE_AW; i++) h[i % SIDX_W] = h[i % SIDX_W] ^ l[i];
    return h;
  endfunction

  logic [ENT_W-1:0]  new_ent;
  logic [SIDX_W-1:0] s_idx;
  assign new_ent = {req_pos, req_fix};
  assign s_idx   = set_of(req_line);

  // local per-line state
  logic             loc_vld;
  logic [ENT_W-1:0] loc_ent;
  ovf_e             loc_st;
  logic             loc_we;
  logic             st_we;
  ovf_e             st_new;

  ocp_local_meta #(.LINE_AW(LINE_AW), .ENT_W(ENT_W)) u_local (
    .clk       (clk),
    .rst       (rst),
    .line      (req_line),
    .ent_we    (loc_we),
    .ent_wdata (new_ent),
    .st_we     (st_we),
    .st_wdata  (st_new),
    .rd_valid  (loc_vld),
    .rd_ent    (loc_ent),
    .rd_state  (loc_st)
  );

  // primary table
  logic [SAT_WAYS-1:0]              s_vld;
  logic [SAT_WAYS-1:0][LINE_AW-1:0] s_tag;
  logic [SAT_WAYS-1:0][ENT_W-1:0]   s_ent;
  logic                             s_ovf;
  logic [GIDX_W-1:0]                s_head_a, s_head_b;
  logic                             sat_we, link_we;
  logic [SW_W-1:0]                  s_free_way;
  logic                             s_full;

  // collision table
  logic [GCT_WAYS-1:0]              g_vld;
  logic [GCT_WAYS-1:0][LINE_AW-1:0] g_tag;
  logic [GCT_WAYS-1:0][ENT_W-1:0]   g_ent;
  logic                             g_free_any;
  logic [GIDX_W-1:0]                g_free_idx;
  logic [GIDX_W-1:0]                g_idx;
  logic                             gct_we, claim_en;
  logic [GW_W-1:0]                  g_free_way;
  logic                             g_full;
  logic                             link_ok;

  assign link_ok = s_ovf && (s_head_a == s_head_b);
  assign g_idx   = s_ovf ? s_head_a : g_free_idx;

  ocp_sat #(
    .SETS(SAT_SETS), .WAYS(SAT_WAYS), .TAG_W(LINE_AW), .ENT_W(ENT_W), .HEAD_W(GIDX_W)
  ) u_sat (
    .clk       (clk),
    .rst       (rst),
    .idx       (s_idx),
    .we        (sat_we),
    .way       (s_free_way),
    .wtag      (req_line),
    .went      (new_ent),
    .link_we   (link_we),
    .link_head (g_free_idx),
    .rd_vld    (s_vld),
    .rd_tag    (s_tag),
    .rd_ent    (s_ent),
    .rd_ovf    (s_ovf),
    .rd_head_a (s_head_a),
    .rd_head_b (s_head_b)
  );

  ocp_gct #(
    .SETS(GCT_SETS), .WAYS(GCT_WAYS), .TAG_W(LINE_AW), .ENT_W(ENT_W)
  ) u_gct (
    .clk      (clk),
    .rst      (rst),
    .idx      (g_idx),
    .we       (gct_we),
    .way      (g_free_way),
    .wtag     (req_line),
    .went     (new_ent),
    .claim_en (claim_en),
    .rd_vld   (g_vld),
    .rd_tag   (g_tag),
    .rd_ent   (g_ent),
    .free_any (g_free_any),
    .free_idx (g_free_idx)
  );

  // lowest free way in each table
  always_comb begin
    s_full     = 1'b1;
    s_free_way = '0;
    for (int w = SAT_WAYS - 1; w >= 0; w--) begin
      if (!s_vld[w]) begin
        s_full     = 1'b0;
        s_free_way = SW_W'(w);
      end
    end
  end

  always_comb begin
    g_full     = 1'b1;
    g_free_way = '0;
    for (int w = GCT_WAYS - 1; w >= 0; w--) begin
      if (!g_vld[w]) begin
        g_full     = 1'b0;
        g_free_way = GW_W'(w);
      end
    end
  end

  // allocation decision: local slot, primary way, chained set, new chain
  logic alloc_ok, alloc_extra;

  always_comb begin
    loc_we      = 1'b0;
    st_we       = 1'b0;
    st_new      = loc_st;
    sat_we      = 1'b0;
    gct_we      = 1'b0;
    claim_en    = 1'b0;
    link_we     = 1'b0;
    alloc_ok    = 1'b0;
    alloc_extra = 1'b0;
    if (req_valid && req_op == OP_ALLOC) begin
      if (!loc_vld) begin
        loc_we   = 1'b1;
        alloc_ok = 1'b1;
      end else if (!s_full) begin
        sat_we   = 1'b1;
        alloc_ok = 1'b1;
        st_we    = 1'b1;
        st_new   = (loc_st == OVF_COL) ? OVF_COL : OVF_PRI;
      end else if (s_ovf) begin
        alloc_extra = 1'b1;
        if (link_ok && !g_full) begin
          gct_we   = 1'b1;
          alloc_ok = 1'b1;
          st_we    = 1'b1;
          st_new   = OVF_COL;
        end
      end else if (g_free_any) begin
        claim_en    = 1'b1;
        link_we     = 1'b1;
        gct_we      = 1'b1;
        alloc_ok    = 1'b1;
        alloc_extra = 1'b1;
        st_we       = 1'b1;
        st_new      = OVF_COL;
      end
    end
  end

  // lookup gather in fixed order
  logic                            use_sat, use_gct;
  logic [MAX_ENT-1:0][ENT_W-1:0]   lk_ents;
  logic [CNT_W-1:0]                lk_cnt;

  assign use_sat = (loc_st != OVF_NONE);
  assign use_gct = (loc_st == OVF_COL) && link_ok;

  always_comb begin
    lk_ents = '0;
    lk_cnt  = '0;
    if (loc_vld) begin
      lk_ents[lk_cnt] = loc_ent;
      lk_cnt          = lk_cnt + CNT_W'(1);
    end
    for (int w = 0; w < SAT_WAYS; w++) begin
      if (use_sat && s_vld[w] && s_tag[w] == req_line) begin
        lk_ents[lk_cnt] = s_ent[w];
        lk_cnt          = lk_cnt + CNT_W'(1);
      end
    end
    for (int w = 0; w < GCT_WAYS; w++) begin
      if (use_gct && g_vld[w] && g_tag[w] == req_line) begin
        lk_ents[lk_cnt] = g_ent[w];
        lk_cnt          = lk_cnt + CNT_W'(1);
      end
    end
  end

  // registered response
  logic [MAX_ENT-1:0][ENT_W-1:0] ents_q;

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_extra <= 1'b0;
      rsp_count <= '0;
      ents_q    <= '0;
    end else begin
      rsp_valid <= 1'b1;
      if (req_op == OP_ALLOC) begin
        rsp_ok    <= alloc_ok;
        rsp_extra <= alloc_extra;
        rsp_count <= '0;
        ents_q    <= '0;
      end else begin
        rsp_ok    <= 1'b1;
        rsp_extra <= use_gct;
        rsp_count <= lk_cnt;
        ents_q    <= lk_ents;
      end
    end
  end

  assign rsp_ents = ents_q;
endmodule

// File: rtl/ocp_checks.sv
module ocp_checks #(
  parameter int CNT_W   = 4,
  parameter int MAX_ENT = 9,
  parameter int HEAD_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_op,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_extra,
  input logic [CNT_W-1:0]  rsp_count,
  input logic              link_ovf,
  input logic [HEAD_W-1:0] head_a,
  input logic [HEAD_W-1:0] head_b
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r9_fail_is_alloc: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> ($past(req_op) == 1'b1 && rsp_count == '0));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_count <= CNT_W'(MAX_ENT)));

  a_r8_chain_has_two: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_extra && $past(req_op) == 1'b0) |-> (rsp_count >= CNT_W'(2)));

  a_r11_alloc_no_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_op) == 1'b1) |-> (rsp_count == '0));

  a_r7_head_copies: assert property (@(posedge clk) disable iff (rst)
    link_ovf |-> (head_a == head_b));
endmodule

bind ovf_corr_pool ocp_checks #(
  .CNT_W(CNT_W), .MAX_ENT(MAX_ENT), .HEAD_W(GIDX_W)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .rsp_extra (rsp_extra),
  .rsp_count (rsp_count),
  .link_ovf  (s_ovf),
  .head_a    (s_head_a),
  .head_b    (s_head_b)
);

// File: tb/ovf_corr_pool_bench.sv
module ovf_corr_pool_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int SETS  = 8;
  localparam int GSETS = 4;
  localparam int SWAYS = 4;
  localparam int GWAYS = 4;
  localparam int K     = 1 + SWAYS + GWAYS;
  localparam int EW    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_op = 1'b0;
  logic [5:0] req_line = '0;
  logic [8:0] req_pos = '0;
  logic req_fix = 1'b0;
  logic rsp_valid, rsp_ok, rsp_extra;
  logic [3:0] rsp_count;
  logic [K*EW-1:0] rsp_ents;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovf_corr_pool u_ovf_corr_pool (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_line(req_line), .req_pos(req_pos), .req_fix(req_fix),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_extra(rsp_extra),
    .rsp_count(rsp_count), .rsp_ents(rsp_ents)
  );

  // reference model state
  int ent_q [LINES][$];
  int sat_used [SETS];
  bit sat_ovf [SETS];
  int sat_head [SETS];
  int gct_used [GSETS];
  int next_gct = 0;
  bit has_gct [LINES];

  bit exp_v = 1'b0;
  bit exp_ok, exp_extra;
  int exp_cnt;
  logic [K*EW-1:0] exp_ents;
  string exp_tag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int hash_of(int l);
    int h = 0;
    for (int i = 0; i < 6; i++) h = h ^ (((l >> i) & 1) << (i % 3));
    return h;
  endfunction

  task automatic check_rsp();
    checks++;
    if (rsp_valid !== exp_v) begin
      fails++;
      $display("FAIL R2: rsp_valid=%0b expected %0b", rsp_valid, exp_v);
    end
    if (exp_v) begin
      checks++;
      if (rsp_ok !== exp_ok || rsp_extra !== exp_extra ||
          rsp_count !== exp_cnt[3:0] || rsp_ents !== exp_ents) begin
        fails++;
        $display("FAIL %s: ok=%0b extra=%0b count=%0d ents=%h expected ok=%0b extra=%0b count=%0d ents=%h",
                 exp_tag, rsp_ok, rsp_extra, rsp_count, rsp_ents,
                 exp_ok, exp_extra, exp_cnt, exp_ents);
      end
    end
  endtask

  task automatic do_req(bit v, bit op, int line, int pos, bit fix);
    int s, g, e;
    @(negedge clk);
    check_rsp();
    exp_v = v;
    exp_ok = 1'b0;
    exp_extra = 1'b0;
    exp_cnt = 0;
    exp_ents = '0;
    exp_tag = "R2";
    if (v) begin
      s = hash_of(line);
      e = (pos << 1) | fix;
      if (op) begin
        if (ent_q[line].size() == 0) begin
          ent_q[line].push_back(e); exp_ok = 1'b1; exp_tag = "R3 alloc local";
        end else if (sat_used[s] < SWAYS) begin
          sat_used[s]++; ent_q[line].push_back(e); exp_ok = 1'b1;
          exp_tag = "R4 R5 alloc primary";
        end else if (sat_ovf[s]) begin
          exp_extra = 1'b1;
          g = sat_head[s];
          if (gct_used[g] < GWAYS) begin
            gct_used[g]++; ent_q[line].push_back(e); has_gct[line] = 1'b1;
            exp_ok = 1'b1; exp_tag = "R7 alloc chained";
          end else exp_tag = "R9 chained set full";
        end else if (next_gct < GSETS) begin
          sat_ovf[s] = 1'b1; sat_head[s] = next_gct; gct_used[next_gct] = 1;
          next_gct++; ent_q[line].push_back(e); has_gct[line] = 1'b1;
          exp_ok = 1'b1; exp_extra = 1'b1; exp_tag = "R6 claim collision set";
        end else exp_tag = "R9 no free collision set";
        if (exp_ok && ent_q[line].size() > 6) exp_tag = "R10 alloc beyond six";
        if (exp_tag == "R3 alloc local") exp_tag = "R3 R11 alloc local";
      end else begin
        exp_ok = 1'b1;
        exp_extra = has_gct[line];
        exp_cnt = ent_q[line].size();
        foreach (ent_q[line][i]) exp_ents[i*EW +: EW] = ent_q[line][i][EW-1:0];
        if (exp_cnt == 0) exp_tag = "R1 R11 empty lookup";
        else if (exp_cnt > 6) exp_tag = "R10 lookup";
        else if (has_gct[line]) exp_tag = "R8 lookup chained";
        else if (exp_cnt == 1) exp_tag = "R3 lookup local";
        else exp_tag = "R5 R8 lookup primary";
      end
    end
    req_valid = v;
    req_op = op;
    req_line = line[5:0];
    req_pos = pos[8:0];
    req_fix = fix;
  endtask

  task automatic alloc_n(int line, int n);
    for (int i = 0; i < n; i++) do_req(1'b1, 1'b1, line, (line * 7 + i * 37) % 512, i[0]);
  endtask

  task automatic lookup(int line);
    do_req(1'b1, 1'b0, line, 0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    foreach (sat_used[i]) begin sat_used[i] = 0; sat_ovf[i] = 1'b0; sat_head[i] = 0; end
    foreach (gct_used[i]) gct_used[i] = 0;
    foreach (has_gct[i]) has_gct[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    lookup(6'h00);
    lookup(6'h3F);
    // R3 local slot, then R5 shared primary set 0
    alloc_n(6'h00, 1);
    lookup(6'h00);
    alloc_n(6'h09, 1);
    lookup(6'h09);
    alloc_n(6'h00, 2);
    alloc_n(6'h09, 2);
    lookup(6'h00);
    lookup(6'h09);
    // R6 claim, R8 lookups
    alloc_n(6'h12, 2);
    lookup(6'h12);
    lookup(6'h00);
    // R7 fill chained set, R9 full
    alloc_n(6'h00, 4);
    lookup(6'h00);
    lookup(6'h12);
    // R10: one line gets nine entries in set 1
    alloc_n(6'h01, 10);
    lookup(6'h01);
    lookup(6'h08);
    // use up remaining collision sets, R9 with none free
    alloc_n(6'h02, 6);
    alloc_n(6'h03, 6);
    alloc_n(6'h04, 6);
    lookup(6'h04);
    lookup(6'h02);
    // idle cycles (R2)
    for (int i = 0; i < 3; i++) do_req(1'b0, 1'b0, 0, 0, 1'b0);
    // pseudo-random mix
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_req(lfsr[15:14] != 2'b00, lfsr[0], int'(lfsr[11:6]), int'(lfsr[13:5]), lfsr[3]);
    end
    do_req(1'b0, 1'b0, 0, 0, 1'b0);
    @(negedge clk);
    check_rsp();
    finish_run();
  end
endmodule